// File: doc/BRIEF.md
# Conditional Branch and Program Counter Unit

This block owns the 16-bit program counter of a small two-byte-instruction processor and carries out its jump-class instructions. Each time the sequencer asserts the step enable, it presents three things: the 5-bit jump operation code, the second instruction byte, and the current zero and carry flags. The unit then decides whether the jump is taken and computes the next program counter. Relative jumps add a signed 8-bit displacement, taken from the instruction itself, to the address that follows the two-byte instruction. The sum wraps at 16 bits.

The unconditional absolute jump takes its target from the following 16-bit instruction word. That word arrives on a separate data input, qualified by a valid strobe. If the word is not present in the same cycle as the step, the unit stalls and holds the program counter until the strobe arrives. A registered `taken` pulse reports every jump that changed the flow. A registered `illegal` pulse reports operation codes that have no defined meaning. Instruction fetch and flag generation are outside this block.

Top module: `branch_pc_unit`

## Requirements
- R1: After a synchronous active-low reset, `pc` is 0x0000 and `taken`, `illegal` and `stall` are all low.
- R2: Operation code 0x00 is always taken. In the cycle after the step, `pc` equals old `pc` + 2 + sign-extended `disp_byte`, and `taken` is high for that one cycle.
- R3: Operation code 0x02 is taken when `flag_z` is 1. Operation code 0x03 is taken when `flag_z` is 0.
- R4: Operation code 0x04 is taken when `flag_c` is 1. Operation code 0x05 is taken when `flag_c` is 0.
- R5: A relative jump that is not taken sets `pc` to old `pc` + 2 and leaves `taken` low, whatever the displacement.
- R6: The displacement is two's complement. Bit 7 set means a negative value, so 0x80 is -128 and 0xFF is -1. All program counter arithmetic wraps modulo 2^16.
- R7: Operation code 0x0F is an absolute jump. If `word_valid` is low at the step, `stall` goes high and `pc` holds. Any `step_en` during the stall is ignored. On the first cycle with `word_valid` high, `pc` loads `word_data`, `taken` pulses and `stall` drops.
- R8: For operation code 0x0F, if `word_valid` is high in the same cycle as the step, `pc` loads `word_data` at once, with no stall cycle. Flags and `disp_byte` have no effect on an absolute jump.
- R9: Every other operation code (anything except 0x00, 0x02, 0x03, 0x04, 0x05 and 0x0F) is treated as not taken: `pc` advances by 2 and `illegal` pulses for one cycle.
- R10: While `step_en` is low and no stall is pending, `pc` holds and `taken` and `illegal` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step_en | input | 1 | A jump instruction is present this cycle |
| jump_op | input | 5 | Jump operation code |
| disp_byte | input | 8 | Second instruction byte; signed displacement |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| word_data | input | 16 | Following instruction word (absolute target) |
| word_valid | input | 1 | `word_data` is valid this cycle |
| pc | output | 16 | Program counter |
| taken | output | 1 | Pulse: last step changed the flow |
| illegal | output | 1 | Pulse: last step had an undefined code |
| stall | output | 1 | Waiting for the absolute target word |

## Verification
The bench builds the unit with its default parameters: a 16-bit program counter, an 8-bit displacement and a 5-bit operation code. Because the code space is only 32 values, the bench can sweep every operation code against all four flag combinations and a set of displacements that includes 0x7F, 0x80 and 0xFF. It computes each expected address arithmetically. An absolute jump first places the counter at 0xFFF0, so that the positive displacements that follow cross the 16-bit wrap point. The stall path is driven directly, including a step issued while the unit waits for the target word.

// File: rtl/bpu_pkg.sv
// Package: shared types and operation-code values for the branch/PC unit.
// Assumes a 5-bit jump operation code taken from the low bits of byte one.
package bpu_pkg;

    localparam int OP_W = 5;

    localparam logic [OP_W-1:0] OPC_REL_ALWAYS = 5'h00;
    localparam logic [OP_W-1:0] OPC_REL_ZSET   = 5'h02;
    localparam logic [OP_W-1:0] OPC_REL_ZCLR   = 5'h03;
    localparam logic [OP_W-1:0] OPC_REL_CSET   = 5'h04;
    localparam logic [OP_W-1:0] OPC_REL_CCLR   = 5'h05;
    localparam logic [OP_W-1:0] OPC_ABS_ALWAYS = 5'h0F;

    // Branch condition class produced by the decoder.
    typedef enum logic [2:0] {
        COND_ALWAYS,
        COND_Z_SET,
        COND_Z_CLR,
        COND_C_SET,
        COND_C_CLR,
        COND_ABSOLUTE,
        COND_UNDEFINED
    } cond_e;

    // Sequencing state of the unit.
    typedef enum logic {
        ST_RUN,
        ST_WAIT_WORD
    } pcu_state_e;

endpackage

// File: rtl/bpu_decode.sv
// Module: bpu_decode
// Maps a jump operation code onto a condition class.
// Assumes: purely combinational; codes that are not defined map to COND_UNDEFINED.
module bpu_decode
    import bpu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output cond_e           cond,
    output logic            undefined
);

    // Code-to-class lookup.
    always_comb begin
        unique case (op)
            OPC_REL_ALWAYS: cond = COND_ALWAYS;
            OPC_REL_ZSET:   cond = COND_Z_SET;
            OPC_REL_ZCLR:   cond = COND_Z_CLR;
            OPC_REL_CSET:   cond = COND_C_SET;
            OPC_REL_CCLR:   cond = COND_C_CLR;
            OPC_ABS_ALWAYS: cond = COND_ABSOLUTE;
            default:        cond = COND_UNDEFINED;
        endcase
    end

    // Flag for codes without meaning.
    always_comb undefined = (cond == COND_UNDEFINED);

endmodule

// File: rtl/bpu_cond_eval.sv
// Module: bpu_cond_eval
// Decides whether a relative jump is taken, from its class and the flags.
// Assumes: absolute and undefined classes never yield a relative take.
module bpu_cond_eval
    import bpu_pkg::*;
(
    input  cond_e cond,
    input  logic  flag_z,
    input  logic  flag_c,
    output logic  rel_take
);

    // Flag test per class.
    always_comb begin
        unique case (cond)
            COND_ALWAYS: rel_take = 1'b1;
            COND_Z_SET:  rel_take = flag_z;
            COND_Z_CLR:  rel_take = ~flag_z;
            COND_C_SET:  rel_take = flag_c;
            COND_C_CLR:  rel_take = ~flag_c;
            default:     rel_take = 1'b0;
        endcase
    end

endmodule

// File: rtl/bpu_target.sv
// Module: bpu_target
// Computes the next PC of a relative jump: the sequential address plus an
// optional sign-extended displacement, wrapping at PC_W bits.
// Assumes: DISP_W >= 1; INSTR_BYTES is the length of the jump instruction.
module bpu_target #(
    parameter int PC_W        = 16,
    parameter int DISP_W      = 8,
    parameter int INSTR_BYTES = 2
) (
    input  logic [PC_W-1:0]   pc_cur,
    input  logic [DISP_W-1:0] disp,
    input  logic              take,
    output logic [PC_W-1:0]   pc_next
);

    localparam logic [PC_W-1:0] SEQ_INC = PC_W'(INSTR_BYTES);

    logic [PC_W-1:0] disp_ext;
    logic [PC_W-1:0] pc_seq;

    // Sign extension or truncation, chosen by the width relation.
    generate
        if (PC_W > DISP_W) begin : g_extend
            always_comb disp_ext = {{(PC_W-DISP_W){disp[DISP_W-1]}}, disp};
        end else begin : g_trunc
            always_comb disp_ext = disp[PC_W-1:0];
        end
    endgenerate

    // Address after the jump instruction has been consumed.
    always_comb pc_seq = pc_cur + SEQ_INC;

    // Apply the displacement only when the jump is taken.
    always_comb pc_next = take ? (pc_seq + disp_ext) : pc_seq;

endmodule

// File: rtl/branch_pc_unit.sv
// Module: branch_pc_unit (top)
// Holds the program counter and executes jump-class instructions:
// flag-conditioned relative jumps and an absolute jump that waits for the
// following instruction word. Assumes step_en marks one jump instruction per
// cycle. Synchronous active-low reset.
module branch_pc_unit
    import bpu_pkg::*;
#(
    parameter int PC_W        = 16,
    parameter int DISP_W      = 8,
    parameter int INSTR_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_en,
    input  logic [OP_W-1:0]   jump_op,
    input  logic [DISP_W-1:0] disp_byte,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic [PC_W-1:0]   word_data,
    input  logic              word_valid,
    output logic [PC_W-1:0]   pc,
    output logic              taken,
    output logic              illegal,
    output logic              stall
);

    localparam logic [PC_W-1:0] SEQ_INC = PC_W'(INSTR_BYTES);

    cond_e           cond;
    logic            undefined;
    logic            rel_take;
    logic [PC_W-1:0] rel_next;
    pcu_state_e      state_q, state_d;
    logic [PC_W-1:0] pc_q, pc_d;
    logic            taken_q, taken_d;
    logic            illegal_q, illegal_d;

    bpu_decode u_decode (
        .op        (jump_op),
        .cond      (cond),
        .undefined (undefined)
    );

    bpu_cond_eval u_eval (
        .cond     (cond),
        .flag_z   (flag_z),
        .flag_c   (flag_c),
        .rel_take (rel_take)
    );

    bpu_target #(
        .PC_W        (PC_W),
        .DISP_W      (DISP_W),
        .INSTR_BYTES (INSTR_BYTES)
    ) u_target (
        .pc_cur  (pc_q),
        .disp    (disp_byte),
        .take    (rel_take),
        .pc_next (rel_next)
    );

    // Next-state selection for PC, pulses and the wait state.
    always_comb begin
        state_d   = state_q;
        pc_d      = pc_q;
        taken_d   = 1'b0;
        illegal_d = 1'b0;
        if (state_q == ST_WAIT_WORD) begin
            if (word_valid) begin
                pc_d    = word_data;
                taken_d = 1'b1;
                state_d = ST_RUN;
            end
        end else if (step_en) begin
            if (cond == COND_ABSOLUTE) begin
                if (word_valid) begin
                    pc_d    = word_data;
                    taken_d = 1'b1;
                end else begin
                    state_d = ST_WAIT_WORD;
                end
            end else begin
                pc_d      = rel_next;
                taken_d   = rel_take;
                illegal_d = undefined;
            end
        end
    end

    // State registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_RUN;
            pc_q      <= '0;
            taken_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            pc_q      <= pc_d;
            taken_q   <= taken_d;
            illegal_q <= illegal_d;
        end
    end

    assign pc      = pc_q;
    assign taken   = taken_q;
    assign illegal = illegal_q;
    assign stall   = (state_q == ST_WAIT_WORD);

    // Assertions guarding the sequencing logic.
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pc == '0 && !taken && !illegal && !stall)); // R1

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !word_valid) |=> (stall && $stable(pc) && !taken)); // R7

    AST_WORD_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && word_valid) |=> (taken && !stall && pc == $past(word_data))); // R7

    AST_REL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && step_en && jump_op != OPC_ABS_ALWAYS)
            |=> (taken || pc == $past(pc) + SEQ_INC)); // R5

    AST_ILLEGAL_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !taken); // R9

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stall && !step_en) |=> ($stable(pc) && !taken && !illegal)); // R10

endmodule

// File: tb/branch_pc_unit_tb_top.sv
// Bench: sweeps every operation code against all flag combinations and a
// set of displacements, with expected PCs computed arithmetically.
module branch_pc_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_en = 1'b0;
    logic [4:0]  jump_op = '0;
    logic [7:0]  disp_byte = '0;
    logic        flag_z = 1'b0;
    logic        flag_c = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_valid = 1'b0;
    logic [15:0] pc;
    logic        taken, illegal, stall;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;
    logic [15:0] model_pc = '0;

    always #4 clk = ~clk;   // 125 MHz

    branch_pc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .step_en(step_en), .jump_op(jump_op),
        .disp_byte(disp_byte), .flag_z(flag_z), .flag_c(flag_c),
        .word_data(word_data), .word_valid(word_valid),
        .pc(pc), .taken(taken), .illegal(illegal), .stall(stall)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge pass, return at next falling edge.
    task automatic cycle(input logic se, input logic [4:0] op, input logic [7:0] d,
                         input logic z, input logic c, input logic wv, input logic [15:0] wd);
        step_en = se; jump_op = op; disp_byte = d; flag_z = z; flag_c = c;
        word_valid = wv; word_data = wd;
        @(negedge clk);
        step_en = 1'b0; word_valid = 1'b0;
    endtask

    function automatic int take_of(input logic [4:0] op, input logic z, input logic c);
        case (op)
            5'h00: return 1;
            5'h02: return z ? 1 : 0;
            5'h03: return z ? 0 : 1;
            5'h04: return c ? 1 : 0;
            5'h05: return c ? 0 : 1;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_legal(input logic [4:0] op);
        return (op == 5'h00 || op == 5'h02 || op == 5'h03 ||
                op == 5'h04 || op == 5'h05 || op == 5'h0F);
    endfunction

    initial begin
        logic [7:0] disps [6];
        disps = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'hFF, 8'h10};
        @(negedge clk); @(negedge clk);
        check("R1 pc", pc, 16'h0);
        check("R1 flags", {taken, illegal, stall}, 3'b000);
        rst_n = 1'b1;
        // R10: idle cycles hold pc
        cycle(1'b0, 5'h00, 8'h40, 1'b1, 1'b1, 1'b0, 16'h0);
        check("R10 pc", pc, 16'h0);
        check("R10 pulses", {taken, illegal}, 2'b00);
        // R8: immediate absolute load to near the top, flags/disp irrelevant
        cycle(1'b1, 5'h0F, 8'h55, 1'b1, 1'b0, 1'b1, 16'hFFF0);
        model_pc = 16'hFFF0;
        check("R8 pc", pc, model_pc);
        check("R8 taken/stall", {taken, stall}, 2'b10);
        // Sweep: all codes x flags x displacements (R2..R6, R9)
        for (int op = 0; op < 32; op++) begin
            for (int f = 0; f < 4; f++) begin
                for (int k = 0; k < 6; k++) begin
                    logic [4:0] o;
                    logic z, c;
                    int tk;
                    o = 5'(op); z = f[0]; c = f[1];
                    if (o == 5'h0F) begin
                        cycle(1'b1, o, disps[k], z, c, 1'b1, 16'(16'h1234 + 16'(k * 257)));
                        model_pc = 16'(16'h1234 + 16'(k * 257));
                        check("R8 abs sweep pc", pc, model_pc);
                        check("R8 abs sweep taken", taken, 1'b1);
                    end else begin
                        tk = take_of(o, z, c);
                        cycle(1'b1, o, disps[k], z, c, 1'b0, 16'hDEAD);
                        model_pc = model_pc + 16'd2 + (tk != 0 ? {{8{disps[k][7]}}, disps[k]} : 16'd0);
                        if (o == 5'h00) check("R2 pc", pc, model_pc);
                        else if (o == 5'h02 || o == 5'h03) check("R3 pc", pc, model_pc);
                        else if (o == 5'h04 || o == 5'h05) check("R4 pc", pc, model_pc);
                        else check("R5/R9 pc", pc, model_pc);
                        check("R6 pc wrap/sign", pc, model_pc);
                        check("R5 taken", taken, tk[0]);
                        check("R9 illegal", illegal, !is_legal(o));
                    end
                end
            end
        end
        // R6: wrap from top with positive displacement
        cycle(1'b1, 5'h0F, 8'h00, 1'b0, 1'b0, 1'b1, 16'hFFF0);
        cycle(1'b1, 5'h00, 8'h7F, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R6 wrap", pc, 16'h0071);
        // R7: stall path
        cycle(1'b1, 5'h0F, 8'h00, 1'b0, 1'b0, 1'b0, 16'hBEEF);
        check("R7 stall", stall, 1'b1);
        check("R7 pc held", pc, 16'h0071);
        cycle(1'b1, 5'h00, 8'h20, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R7 step ignored pc", pc, 16'h0071);
        check("R7 still stalled", {stall, taken}, 2'b10);
        cycle(1'b0, 5'h00, 8'h00, 1'b0, 1'b0, 1'b1, 16'hA5A4);
        check("R7 load pc", pc, 16'hA5A4);
        check("R7 taken/stall", {taken, stall}, 2'b10);
        cycle(1'b0, 5'h00, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0);
        check("R10 after load", {pc, taken}, {16'hA5A4, 1'b0});
        // R1: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset again", {pc, taken, illegal, stall}, {16'h0, 3'b000});
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule